// File: doc/BRIEF.md
# Graceful Halt and Transmit Poll Controller

This block sits beside a DMA engine's control register and turns writes to that register into two kinds of action. The first is a graceful halt of either data direction. Software sets a halt bit for receive or transmit. The controller then reports completion with a one-cycle event-set strobe. If no frame is moving in that direction, the strobe follows the write at once. If a frame is moving, the strobe waits until that frame has ended. Clearing the halt bit before the frame ends withdraws the request.

The second action is a periodic transmit poll. Any control write whose wait bit is clear restarts a countdown of one full poll period. Each time the countdown expires, it rearms and pulses a kick toward transmit ring 0. The kick is withheld while the stored transmit-halt bit is set. Writing the wait bit as 1 stops the countdown altogether.

The poll period is a parameter in clock cycles. By default it is the system clock divided by 100. Descriptor handling lives elsewhere. This block produces only the strobes.

Top module: `halt_poll_ctl`

## Requirements
- R1: While reset is held and after it is released, with no control write yet, rx_halt_done, tx_halt_done and ring0_kick stay low, and the poll countdown is idle.
- R2: A write with the receive-halt bit (ctl_wdata bit 2) set, in a cycle where rx_busy is low or rx_eof is high, raises rx_halt_done for exactly the one cycle after the write.
- R3: A write with the receive-halt bit set, while rx_busy is high and rx_eof is low, produces no rx_halt_done until rx_eof pulses. rx_halt_done is then high for exactly the one cycle after the rx_eof cycle.
- R4: Transmit halt (ctl_wdata bit 3) behaves as in R2 and R3, using tx_busy, tx_eof and tx_halt_done. It has no effect on rx_halt_done.
- R5: A later write with the halt bit of a direction clear cancels that direction's pending halt. The following frame end then raises no halt strobe.
- R6: A write with the wait bit (ctl_wdata bit 7) clear restarts polling. With a period of P cycles and the write in cycle 0, ring0_kick is high for one cycle in cycle P+1 and then every P cycles. A write that lands in an expiry cycle suppresses that expiry's kick.
- R7: While the most recently written transmit-halt bit is 1, the countdown keeps running but ring0_kick stays low. A later write with both the halt bit and the wait bit clear brings kicks back on the R6 schedule.
- R8: A write with the wait bit set stops the countdown. No ring0_kick occurs until a later write has the wait bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | CTL_W | Control register write data |
| rx_busy | input | 1 | A receive frame is in progress |
| rx_eof | input | 1 | One-cycle receive frame-end pulse |
| tx_busy | input | 1 | A transmit frame is in progress |
| tx_eof | input | 1 | One-cycle transmit frame-end pulse |
| rx_halt_done | output | 1 | Event-set strobe: receive halt complete |
| tx_halt_done | output | 1 | Event-set strobe: transmit halt complete |
| ring0_kick | output | 1 | Poll kick for transmit ring 0 |

## Verification
The bench builds the block with a poll period of 5 cycles and the default bit positions. With that period, every restart offset within one period can be swept. It also makes kick spacing visible over several periods in a short run. Frame-end latencies from 0 to 4 cycles are swept for both directions, for completed halts and for cancelled ones. A frame end that coincides with the halt write is also applied.

// File: rtl/halt_poll_pkg.sv
package halt_poll_pkg;

   typedef enum int unsigned {
      DIR_RX = 0,
      DIR_TX = 1
   } dir_e;

   localparam int unsigned NUM_DIR = 2;

   function automatic int unsigned halt_pos(input int unsigned dir,
                                            input int unsigned rx_pos,
                                            input int unsigned tx_pos);
      return (dir == DIR_RX) ? rx_pos : tx_pos;
   endfunction

endpackage

// File: rtl/halt_seq.sv
module halt_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic req_wr,
   input  logic req_halt,
   input  logic busy,
   input  logic eof,
   output logic done
);

   logic pend_q;
   logic done_q;
   logic idle_now;

   // a frame ending in this very cycle counts as idle
   assign idle_now = !busy || eof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (req_wr) begin
            if (req_halt) begin
               if (idle_now) begin
                  done_q <= 1'b1;
                  pend_q <= 1'b0;
               end else begin
                  pend_q <= 1'b1;
               end
            end else begin
               pend_q <= 1'b0;
            end
         end else if (pend_q && eof) begin
            done_q <= 1'b1;
            pend_q <= 1'b0;
         end
      end
   end

   assign done = done_q;

endmodule

// File: rtl/poll_tick.sv
module poll_tick #(
   parameter int unsigned PERIOD = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic halt,
   input  logic tx_stopped,
   output logic kick
);

   localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic          kick_q;
   logic          expire;

   assign expire = run_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         kick_q <= 1'b0;
      end else begin
         kick_q <= 1'b0;
         if (restart) begin
            run_q <= 1'b1;
            cnt_q <= RELOAD;
         end else if (halt) begin
            run_q <= 1'b0;
         end else if (expire) begin
            cnt_q  <= RELOAD;
            kick_q <= !tx_stopped;
         end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign kick = kick_q;

endmodule

// File: rtl/halt_poll_ctl.sv
module halt_poll_ctl #(
   parameter int unsigned CTL_W       = 8,
   parameter int unsigned RX_HALT_BIT = 2,
   parameter int unsigned TX_HALT_BIT = 3,
   parameter int unsigned WAIT_BIT    = 7,
   parameter int unsigned CLK_HZ      = 100000000,
   parameter int unsigned POLL_HZ     = 100,
   parameter int unsigned POLL_CYCLES = CLK_HZ / POLL_HZ
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             rx_busy,
   input  logic             rx_eof,
   input  logic             tx_busy,
   input  logic             tx_eof,
   output logic             rx_halt_done,
   output logic             tx_halt_done,
   output logic             ring0_kick
);
   import halt_poll_pkg::*;

   if (POLL_CYCLES < 2) begin : g_bad_period
      $error("halt_poll_ctl: POLL_CYCLES must be at least 2");
   end
   if (RX_HALT_BIT >= CTL_W || TX_HALT_BIT >= CTL_W || WAIT_BIT >= CTL_W) begin : g_bad_pos
      $error("halt_poll_ctl: control bit position outside CTL_W");
   end
   if (RX_HALT_BIT == TX_HALT_BIT || RX_HALT_BIT == WAIT_BIT || TX_HALT_BIT == WAIT_BIT) begin : g_bad_overlap
      $error("halt_poll_ctl: control bit positions must differ");
   end

   logic [CTL_W-1:0]   ctl_q;
   logic [NUM_DIR-1:0] dir_busy;
   logic [NUM_DIR-1:0] dir_eof;
   logic [NUM_DIR-1:0] dir_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_wr) begin
         ctl_q <= ctl_wdata;
      end
   end

   assign dir_busy[DIR_RX] = rx_busy;
   assign dir_busy[DIR_TX] = tx_busy;
   assign dir_eof[DIR_RX]  = rx_eof;
   assign dir_eof[DIR_TX]  = tx_eof;

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      localparam int unsigned POS = halt_pos(d, RX_HALT_BIT, TX_HALT_BIT);
      halt_seq u_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .req_wr   (ctl_wr),
         .req_halt (ctl_wdata[POS]),
         .busy     (dir_busy[d]),
         .eof      (dir_eof[d]),
         .done     (dir_done[d])
      );
   end

   poll_tick #(.PERIOD(POLL_CYCLES)) u_poll (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (ctl_wr && !ctl_wdata[WAIT_BIT]),
      .halt       (ctl_wr && ctl_wdata[WAIT_BIT]),
      .tx_stopped (ctl_q[TX_HALT_BIT]),
      .kick       (ring0_kick)
   );

   assign rx_halt_done = dir_done[DIR_RX];
   assign tx_halt_done = dir_done[DIR_TX];

endmodule

// File: rtl/halt_poll_chk.sv
module halt_poll_chk #(
   parameter int unsigned CTL_W       = 8,
   parameter int unsigned RX_HALT_BIT = 2,
   parameter int unsigned TX_HALT_BIT = 3,
   parameter int unsigned WAIT_BIT    = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic [CTL_W-1:0] ctl_wdata,
   input logic             rx_busy,
   input logic             rx_eof,
   input logic             tx_busy,
   input logic             tx_eof,
   input logic             rx_halt_done,
   input logic             tx_halt_done,
   input logic             ring0_kick
);

   // polling permission as seen from the port history
   logic seen_poll;
   logic seen_txs;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_poll <= 1'b0;
         seen_txs  <= 1'b0;
      end else if (ctl_wr) begin
         seen_poll <= !ctl_wdata[WAIT_BIT];
         seen_txs  <= ctl_wdata[TX_HALT_BIT];
      end
   end

   a_r2_rx_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_wdata[RX_HALT_BIT] && (!rx_busy || rx_eof) |=> rx_halt_done);

   a_r3_rx_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rx_halt_done |-> $past(rx_eof || (ctl_wr && ctl_wdata[RX_HALT_BIT])));

   a_r4_tx_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && ctl_wdata[TX_HALT_BIT] && (!tx_busy || tx_eof) |=> tx_halt_done);

   a_r4_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
      tx_halt_done |-> $past(tx_eof || (ctl_wr && ctl_wdata[TX_HALT_BIT])));

   a_r5_rx_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && !ctl_wdata[RX_HALT_BIT] |=> !rx_halt_done);

   a_r5_tx_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && !ctl_wdata[TX_HALT_BIT] |=> !tx_halt_done);

   a_r6_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
      ring0_kick |=> !ring0_kick);

   a_r7_r8_kick_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      ring0_kick |-> $past(seen_poll && !seen_txs && !ctl_wr));

endmodule

bind halt_poll_ctl halt_poll_chk #(
   .CTL_W       (CTL_W),
   .RX_HALT_BIT (RX_HALT_BIT),
   .TX_HALT_BIT (TX_HALT_BIT),
   .WAIT_BIT    (WAIT_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_wr       (ctl_wr),
   .ctl_wdata    (ctl_wdata),
   .rx_busy      (rx_busy),
   .rx_eof       (rx_eof),
   .tx_busy      (tx_busy),
   .tx_eof       (tx_eof),
   .rx_halt_done (rx_halt_done),
   .tx_halt_done (tx_halt_done),
   .ring0_kick   (ring0_kick)
);

// File: tb/sim_halt_poll_ctl.sv
module sim_halt_poll_ctl;
   localparam int P   = 5;
   localparam int RXB = 2;
   localparam int TXB = 3;
   localparam int WB  = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       rx_busy = 1'b0, rx_eof = 1'b0, tx_busy = 1'b0, tx_eof = 1'b0;
   logic       rx_halt_done, tx_halt_done, ring0_kick;

   int nvec = 0;
   int nerr = 0;

   always #10 clk = ~clk;

   halt_poll_ctl #(.POLL_CYCLES(P)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .rx_busy(rx_busy), .rx_eof(rx_eof), .tx_busy(tx_busy), .tx_eof(tx_eof),
      .rx_halt_done(rx_halt_done), .tx_halt_done(tx_halt_done),
      .ring0_kick(ring0_kick)
   );

   task automatic chk(input logic got, input logic exp, input string req, input string what);
      nvec++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
      end
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      ctl_wr = 1'b1;
      ctl_wdata = v;
      nxt();
      ctl_wr = 1'b0;
   endtask

   task automatic set_fs(input int d, input logic b, input logic e);
      if (d == 0) begin rx_busy = b; rx_eof = e; end
      else begin tx_busy = b; tx_eof = e; end
   endtask

   function automatic logic done_of(input int d);
      return (d == 0) ? rx_halt_done : tx_halt_done;
   endfunction

   function automatic logic other_of(input int d);
      return (d == 0) ? tx_halt_done : rx_halt_done;
   endfunction

   // check kick for ncyc negedges; first = 0 means no kick expected
   task automatic poll_watch(input int ncyc, input int first, input string req);
      for (int k = 1; k <= ncyc; k++) begin
         logic e;
         e = (first > 0) && (k >= first) && (((k - first) % P) == 0);
         chk(ring0_kick, e, req, $sformatf("kick at cycle %0d", k));
         nxt();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (3) nxt();
      chk(rx_halt_done, 1'b0, "R1", "rx done in reset");
      chk(tx_halt_done, 1'b0, "R1", "tx done in reset");
      chk(ring0_kick, 1'b0, "R1", "kick in reset");
      rst_n = 1'b1;
      for (int k = 0; k < 3 * P; k++) begin
         nxt();
         chk(rx_halt_done, 1'b0, "R1", "rx done idle");
         chk(tx_halt_done, 1'b0, "R1", "tx done idle");
         chk(ring0_kick, 1'b0, "R1", "no kick before any write");
      end

      for (int d = 0; d < 2; d++) begin
         string req;
         logic [7:0] hb;
         req = (d == 0) ? "R2" : "R4";
         hb = 8'(1 << ((d == 0) ? RXB : TXB)) | 8'(1 << WB);
         // immediate halt, frame idle
         set_fs(d, 1'b0, 1'b0);
         wr(hb);
         chk(done_of(d), 1'b1, req, "immediate done");
         chk(other_of(d), 1'b0, req, "other direction quiet");
         nxt();
         chk(done_of(d), 1'b0, req, "immediate done one cycle");
         // frame ends in the write cycle
         set_fs(d, 1'b1, 1'b1);
         wr(hb);
         set_fs(d, 1'b0, 1'b0);
         chk(done_of(d), 1'b1, req, "done with eof in write cycle");
         nxt();
         chk(done_of(d), 1'b0, req, "eof-write done one cycle");

         req = (d == 0) ? "R3" : "R4";
         for (int lat = 0; lat < 5; lat++) begin
            set_fs(d, 1'b1, 1'b0);
            wr(hb);
            chk(done_of(d), 1'b0, req, $sformatf("held at write, lat %0d", lat));
            for (int k = 0; k < lat; k++) begin
               nxt();
               chk(done_of(d), 1'b0, req, $sformatf("held mid-frame, lat %0d", lat));
            end
            set_fs(d, 1'b1, 1'b1);
            nxt();
            set_fs(d, 1'b0, 1'b0);
            chk(done_of(d), 1'b1, req, $sformatf("done after eof, lat %0d", lat));
            chk(other_of(d), 1'b0, req, "other direction quiet");
            nxt();
            chk(done_of(d), 1'b0, req, $sformatf("deferred done one cycle, lat %0d", lat));
         end

         for (int lat = 0; lat < 4; lat++) begin
            set_fs(d, 1'b1, 1'b0);
            wr(hb);
            for (int k = 0; k < lat; k++) nxt();
            wr(8'(1 << WB));
            chk(done_of(d), 1'b0, "R5", "no done on cancel write");
            set_fs(d, 1'b1, 1'b1);
            nxt();
            set_fs(d, 1'b0, 1'b0);
            for (int k = 0; k < 3; k++) begin
               chk(done_of(d), 1'b0, "R5", $sformatf("cancelled, lat %0d", lat));
               nxt();
            end
         end
      end

      // polling
      wr(8'h00);
      poll_watch(4 * P, P + 1, "R6");
      for (int r = 1; r < P; r++) begin
         wr(8'h00);
         poll_watch(r, P + 1, "R6");
         wr(8'h00);
         poll_watch(2 * P + 2, P + 1, "R6");
      end
      wr(8'(1 << TXB));
      poll_watch(3 * P, 0, "R7");
      wr(8'h00);
      poll_watch(2 * P + 2, P + 1, "R7");
      wr(8'(1 << WB));
      poll_watch(4 * P, 0, "R8");
      wr(8'h00);
      poll_watch(2 * P + 2, P + 1, "R8");

      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule